// File: doc/BRIEF.md
# Multi-Core Level Interrupt Router

This block collects a configurable number of level-sensitive interrupt sources and steers each one onto one interrupt line of one processor core. Every source has a pending bit, an enable bit, a pin selection and a core selection. All of them are held in registers that software reaches through a simple 32-bit memory-mapped bus. Each core receives a small bundle of level outputs. An output is high when at least one enabled, pending source is mapped to that core and pin.

Software can raise or drop any source's pending bit through a trigger register, without touching the wire. Each core also has a local compare-pending input, which comes from a separate timer block. This input joins the same OR when the core's compare mask is set and the compare pin map selects that line. Software turns enables on and off through two separate banks: a write-one-to-set bank and a write-one-to-clear bank. It writes the core selection as a one-hot vector, and the block stores it as an index.

The source count `NUM_SRC` must be a nonzero multiple of 8 and at most 256. The default is 256.

Top module: `irq_router`

## Requirements
- R1: After reset every source is disabled, not pending and unmapped (its core-map word at 0x1000+32*n reads 0). Its pin-map word at 0x0400+4*n reads 0x8000_0000 (map flag set, pin 0). Each core's compare mask (0x3000+8*c, bit 0) reads 1, its compare pin map (0x3004+8*c) reads 0x8000_0000, and all outputs are 0.
- R2: The word at 0x0000 is read-only. Bits [7:0] hold NUM_SRC/8-1 and bits [23:16] hold NUM_CORE.
- R3: A write to the set-enable bank at 0x0180+4*k enables source 32k+i for each bit i written as 1. Bits written as 0 change nothing.
- R4: A write to the clear-enable bank at 0x0200+4*k disables source 32k+i for each bit i written as 1. Bits written as 0 change nothing.
- R5: The pending status at 0x0080+4*k and the enable status at 0x0100+4*k give source 32k+i in bit i, so the first source of a byte offset is that offset times 8. Bits beyond NUM_SRC read 0.
- R6: A pin-map write stores bit 31 (map flag) and the pin in bits [2:0]. The write is rejected and leaves the register unchanged when bits [5:0] exceed 5. The same rule applies to each core's compare pin map.
- R7: A core-map write stores the index of the lowest set bit, and a write of 0 unmaps the source. The write is rejected when that index is not below NUM_CORE. A read returns 1 shifted left by the stored index, or 0 when unmapped.
- R8: Output irq_o[c*8 + pin + 2] is the OR of pending AND enabled over the sources mapped to core c with that pin. Lines c*8 and c*8+1 are always 0.
- R9: cmp_pend_i[c] also drives irq_o[c*8 + cpin + 2] while core c's compare mask is 1. Here cpin is core c's compare pin.
- R10: At 0x0004, a write with bit 31 = 1 sets, and with bit 31 = 0 clears, the pending bit of the source given by bits [30:0]. An index not below NUM_SRC is ignored.
- R11: A change of a source input level is stored as that source's pending bit even while the source is disabled. Enabling the source later drives the output from that stored bit.
- R12: The outputs are registered. They change at the first rising clock edge that samples the register write or the input change.
- R13: A read of an unmapped or misaligned offset returns 0, and a write to one changes no state. Read data appears the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_SRC | Level interrupt sources |
| cmp_pend_i | input | NUM_CORE | Per-core local compare pending levels |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after a read request |
| irq_o | output | NUM_CORE*8 | Per-core interrupt lines, 8 per core |

## Verification
Register writes, trigger writes and source-level changes are sampled at one rising edge, and their effect on irq_o is visible right after that edge. The bench drives stimulus on the falling edge and checks irq_o on the next falling edge. Read data is registered, so the bench captures rdata_o one falling edge after presenting the address. For R12, the bench also samples irq_o between the input change and the rising edge, and expects the old value there and the new value at the next falling edge.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 32;
    localparam int MAX_PIN  = 5;
    localparam int PIN_OFS  = 2;
    localparam int OUT_PINS = PIN_OFS + MAX_PIN + 1;
    localparam int PIN_W    = 3;

    localparam logic [ADDR_W-1:0] OFS_CONFIG  = 16'h0000;
    localparam logic [ADDR_W-1:0] OFS_SWTRIG  = 16'h0004;
    localparam logic [ADDR_W-1:0] OFS_PEND    = 16'h0080;
    localparam logic [ADDR_W-1:0] OFS_ENST    = 16'h0100;
    localparam logic [ADDR_W-1:0] OFS_ENSET   = 16'h0180;
    localparam logic [ADDR_W-1:0] OFS_ENCLR   = 16'h0200;
    localparam logic [ADDR_W-1:0] OFS_PINMAP  = 16'h0400;
    localparam logic [ADDR_W-1:0] OFS_COREMAP = 16'h1000;
    localparam logic [ADDR_W-1:0] OFS_LOCAL   = 16'h3000;

    // word-aligned address inside [base, base+span)
    function automatic logic win_hit(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] base,
                                     input int unsigned span);
        return (a >= base) && (32'(a) < 32'(base) + span) && (a[1:0] == 2'b00);
    endfunction

    // index of the lowest set bit, 32 when none
    function automatic logic [5:0] lowest_one(input logic [DATA_W-1:0] v);
        logic [5:0] r;
        r = 6'd32;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            if (v[i]) r = 6'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/irq_route_or.sv
module irq_route_or
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC  = 256,
    parameter int NUM_CORE = 2,
    localparam int CORE_W  = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1
) (
    input  logic [NUM_SRC-1:0]                  pend,
    input  logic [NUM_SRC-1:0]                  en,
    input  logic [NUM_SRC-1:0]                  cvld,
    input  logic [NUM_SRC-1:0][CORE_W-1:0]      cidx,
    input  logic [NUM_SRC-1:0][PIN_W-1:0]       pin,
    input  logic [NUM_CORE-1:0]                 cmp_pend,
    input  logic [NUM_CORE-1:0]                 cmp_mask,
    input  logic [NUM_CORE-1:0][PIN_W-1:0]      cmp_pin,
    output logic [NUM_CORE*OUT_PINS-1:0]        lines
);
    for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
        for (genvar p = 0; p < OUT_PINS; p++) begin : g_line
            if (p < PIN_OFS) begin : g_unused
                assign lines[c*OUT_PINS+p] = 1'b0;
            end else begin : g_used
                logic hit;
                always_comb begin
                    hit = cmp_pend[c] && cmp_mask[c] &&
                          (cmp_pin[c] == PIN_W'(p - PIN_OFS));
                    for (int s = 0; s < NUM_SRC; s++) begin
                        if (pend[s] && en[s] && cvld[s] &&
                            (cidx[s] == CORE_W'(c)) &&
                            (pin[s] == PIN_W'(p - PIN_OFS)))
                            hit = 1'b1;
                    end
                end
                assign lines[c*OUT_PINS+p] = hit;
            end
        end
    end
endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC  = 256,
    parameter int NUM_CORE = 2,
    localparam int CORE_W  = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1,
    localparam int WORDS   = (NUM_SRC + 31) / 32
) (
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [NUM_SRC-1:0]                  pend,
    input  logic [NUM_SRC-1:0]                  en,
    input  logic [NUM_SRC-1:0]                  cvld,
    input  logic [NUM_SRC-1:0][CORE_W-1:0]      cidx,
    input  logic [NUM_SRC-1:0][PIN_W-1:0]       pin,
    input  logic [NUM_SRC-1:0]                  pflag,
    input  logic [NUM_CORE-1:0]                 cmp_mask,
    input  logic [NUM_CORE-1:0][PIN_W-1:0]      cmp_pin,
    input  logic [NUM_CORE-1:0]                 cmp_flag,
    output logic [DATA_W-1:0]                   rdata
);
    logic [ADDR_W-1:0] o_pend, o_en, o_pin, o_core, o_loc;

    always_comb begin
        o_pend = (addr - OFS_PEND) >> 2;
        o_en   = (addr - OFS_ENST) >> 2;
        o_pin  = (addr - OFS_PINMAP) >> 2;
        o_core = (addr - OFS_COREMAP) >> 5;
        o_loc  = (addr - OFS_LOCAL) >> 3;
        rdata  = '0;
        if (addr == OFS_CONFIG) begin
            rdata = {8'd0, 8'(NUM_CORE), 8'd0, 8'(NUM_SRC / 8 - 1)};
        end
        if (win_hit(addr, OFS_PEND, 4 * WORDS)) begin
            for (int s = 0; s < NUM_SRC; s++)
                if (16'(s / 32) == o_pend) rdata[s % 32] = pend[s];
        end
        if (win_hit(addr, OFS_ENST, 4 * WORDS)) begin
            for (int s = 0; s < NUM_SRC; s++)
                if (16'(s / 32) == o_en) rdata[s % 32] = en[s];
        end
        if (win_hit(addr, OFS_PINMAP, 4 * NUM_SRC)) begin
            for (int s = 0; s < NUM_SRC; s++)
                if (16'(s) == o_pin) rdata = {pflag[s], 28'd0, pin[s]};
        end
        if (win_hit(addr, OFS_COREMAP, 32 * NUM_SRC) && (addr[4:0] == 5'd0)) begin
            for (int s = 0; s < NUM_SRC; s++)
                if ((16'(s) == o_core) && cvld[s]) rdata = 32'd1 << cidx[s];
        end
        if (win_hit(addr, OFS_LOCAL, 8 * NUM_CORE)) begin
            for (int c = 0; c < NUM_CORE; c++) begin
                if (16'(c) == o_loc) begin
                    if (addr[2]) rdata = {cmp_flag[c], 28'd0, cmp_pin[c]};
                    else         rdata = {31'd0, cmp_mask[c]};
                end
            end
        end
    end
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC  = 256,
    parameter int NUM_CORE = 2,
    localparam int CORE_W  = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1,
    localparam int SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int WORDS   = (NUM_SRC + 31) / 32,
    localparam int OUT_W   = NUM_CORE * OUT_PINS
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_SRC-1:0]  src_i,
    input  logic [NUM_CORE-1:0] cmp_pend_i,
    input  logic                req_i,
    input  logic                we_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic [OUT_W-1:0]    irq_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0]             pend;
        logic [NUM_SRC-1:0]             en;
        logic [NUM_SRC-1:0]             lvl;
        logic [NUM_SRC-1:0]             cvld;
        logic [NUM_SRC-1:0][CORE_W-1:0] cidx;
        logic [NUM_SRC-1:0][PIN_W-1:0]  pin;
        logic [NUM_SRC-1:0]             pflag;
        logic [NUM_CORE-1:0]            cmask;
        logic [NUM_CORE-1:0][PIN_W-1:0] cpin;
        logic [NUM_CORE-1:0]            cflag;
    } st_t;

    st_t               st_d, st_q;
    logic [OUT_W-1:0]  irq_d, irq_q;
    logic [DATA_W-1:0] rd_d, rd_q;
    logic [ADDR_W-1:0] o_set, o_clr, o_pin, o_core, o_loc;
    logic [5:0]        low;
    logic              wr, pin_ok;

    always_comb begin
        st_d   = st_q;
        wr     = req_i && we_i;
        o_set  = (addr_i - OFS_ENSET) >> 2;
        o_clr  = (addr_i - OFS_ENCLR) >> 2;
        o_pin  = (addr_i - OFS_PINMAP) >> 2;
        o_core = (addr_i - OFS_COREMAP) >> 5;
        o_loc  = (addr_i - OFS_LOCAL) >> 3;
        low    = lowest_one(wdata_i);
        pin_ok = (wdata_i[5:0] <= 6'(MAX_PIN));

        if (wr && addr_i == OFS_SWTRIG && wdata_i[30:0] < 31'(NUM_SRC))
            st_d.pend[wdata_i[SRC_W-1:0]] = wdata_i[31];

        for (int s = 0; s < NUM_SRC; s++) begin
            if (wr && win_hit(addr_i, OFS_ENSET, 4 * WORDS) &&
                16'(s / 32) == o_set && wdata_i[s % 32])
                st_d.en[s] = 1'b1;
            if (wr && win_hit(addr_i, OFS_ENCLR, 4 * WORDS) &&
                16'(s / 32) == o_clr && wdata_i[s % 32])
                st_d.en[s] = 1'b0;
            if (wr && win_hit(addr_i, OFS_PINMAP, 4 * NUM_SRC) &&
                16'(s) == o_pin && pin_ok) begin
                st_d.pin[s]   = wdata_i[PIN_W-1:0];
                st_d.pflag[s] = wdata_i[31];
            end
            if (wr && win_hit(addr_i, OFS_COREMAP, 32 * NUM_SRC) &&
                addr_i[4:0] == 5'd0 && 16'(s) == o_core) begin
                if (wdata_i == '0) begin
                    st_d.cvld[s] = 1'b0;
                end else if (int'(low) < NUM_CORE) begin
                    st_d.cvld[s] = 1'b1;
                    st_d.cidx[s] = CORE_W'(low);
                end
            end
            // a level change on the wire overrides a same-cycle trigger
            if (src_i[s] != st_q.lvl[s]) st_d.pend[s] = src_i[s];
        end
        st_d.lvl = src_i;

        for (int c = 0; c < NUM_CORE; c++) begin
            if (wr && win_hit(addr_i, OFS_LOCAL, 8 * NUM_CORE) && 16'(c) == o_loc) begin
                if (!addr_i[2]) begin
                    st_d.cmask[c] = wdata_i[0];
                end else if (pin_ok) begin
                    st_d.cpin[c]  = wdata_i[PIN_W-1:0];
                    st_d.cflag[c] = wdata_i[31];
                end
            end
        end
    end

    irq_route_or #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE)) u_route (
        .pend     (st_d.pend),
        .en       (st_d.en),
        .cvld     (st_d.cvld),
        .cidx     (st_d.cidx),
        .pin      (st_d.pin),
        .cmp_pend (cmp_pend_i),
        .cmp_mask (st_d.cmask),
        .cmp_pin  (st_d.cpin),
        .lines    (irq_d)
    );

    irq_rd_mux #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE)) u_rd (
        .addr     (addr_i),
        .pend     (st_q.pend),
        .en       (st_q.en),
        .cvld     (st_q.cvld),
        .cidx     (st_q.cidx),
        .pin      (st_q.pin),
        .pflag    (st_q.pflag),
        .cmp_mask (st_q.cmask),
        .cmp_pin  (st_q.cpin),
        .cmp_flag (st_q.cflag),
        .rdata    (rd_d)
    );

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q       <= '0;
            st_q.pflag <= '1;
            st_q.cmask <= '1;
            st_q.cflag <= '1;
            irq_q      <= '0;
            rd_q       <= '0;
        end else begin
            st_q  <= st_d;
            irq_q <= irq_d;
            rd_q  <= (req_i && !we_i) ? rd_d : '0;
        end
    end

    assign irq_o   = irq_q;
    assign rdata_o = rd_q;

    assert_enset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && we_i && addr_i == OFS_ENSET && wdata_i[0]) |=> st_q.en[0]);

    assert_enclr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && we_i && addr_i == OFS_ENCLR && wdata_i[0]) |=> !st_q.en[0]);

    assert_pin_reject_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && we_i && addr_i == OFS_PINMAP && wdata_i[5:0] > 6'(MAX_PIN))
        |=> ($stable(st_q.pin[0]) && $stable(st_q.pflag[0])));

    assert_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.en == '0 && st_q.cmask == '0) |-> irq_o == '0);

    assert_swclr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && we_i && addr_i == OFS_SWTRIG && wdata_i == 32'd0 &&
         src_i[0] == st_q.lvl[0]) |=> !st_q.pend[0]);
endmodule

// File: tb/tb_irq_router.sv
`timescale 1ns/1ps
module tb_irq_router;
    localparam int NS = 16;
    localparam int NC = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NS-1:0]   src = '0;
    logic [NC-1:0]   cmp = '0;
    logic            req = 1'b0, we = 1'b0;
    logic [15:0]     addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic [NC*8-1:0] irq;
    int total = 0, bad = 0;
    logic [31:0] v;

    localparam logic [15:0] A_CFG = 16'h0000, A_TRIG = 16'h0004, A_PEND = 16'h0080,
        A_EN = 16'h0100, A_SET = 16'h0180, A_CLR = 16'h0200, A_PIN = 16'h0400,
        A_CORE = 16'h1000, A_LOC = 16'h3000;

    always #2.5 clk = ~clk;

    irq_router #(.NUM_SRC(NS), .NUM_CORE(NC)) dut (
        .clk_i(clk), .rst_ni(rst_n), .src_i(src), .cmp_pend_i(cmp),
        .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        req = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        req = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        d = rdata; req = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 irq", 32'(irq), 0);
        rd(A_PEND, v); chk("R1 pend", v, 0);
        rd(A_EN, v);   chk("R1 en", v, 0);
        for (int s = 0; s < NS; s++) begin
            rd(A_PIN + 16'(4*s), v);   chk("R1 pinmap", v, 32'h8000_0000);
            rd(A_CORE + 16'(32*s), v); chk("R1 coremap", v, 0);
        end
        for (int c = 0; c < NC; c++) begin
            rd(A_LOC + 16'(8*c), v);     chk("R1 cmp mask", v, 1);
            rd(A_LOC + 16'(8*c + 4), v); chk("R1 cmp pin", v, 32'h8000_0000);
        end
        // R2 config
        rd(A_CFG, v); chk("R2 config", v, {8'd0, 8'(NC), 8'd0, 8'(NS/8 - 1)});

        // R8 / R11 / R5 / R3 / R4 sweep over sources, cores and pins
        for (int s = 0; s < NS; s++) begin
            src[s] = 1'b1; tick();
            chk("R11 disabled source silent", 32'(irq), 0);
            rd(A_PEND, v); chk("R5 pending bit", v, 32'd1 << s);
            for (int c = 0; c < NC; c++) begin
                for (int p = 0; p <= 5; p++) begin
                    wr(A_PIN + 16'(4*s), 32'h8000_0000 | 32'(p));
                    wr(A_CORE + 16'(32*s), 32'd1 << c);
                    wr(A_SET, 32'd1 << s);
                    chk("R8 routed line", 32'(irq), 32'd1 << (c*8 + p + 2));
                    rd(A_EN, v); chk("R3 enable status", v, 32'd1 << s);
                    wr(A_CLR, 32'd1 << s);
                    chk("R4 disabled line", 32'(irq), 0);
                end
            end
            src[s] = 1'b0;
            wr(A_CORE + 16'(32*s), 0);
            rd(A_CORE + 16'(32*s), v); chk("R7 unmapped", v, 0);
        end

        // R3 / R4 zero bits have no effect
        wr(A_SET, 32'h9);  rd(A_EN, v); chk("R3 set", v, 32'h9);
        wr(A_SET, 32'h0);  rd(A_EN, v); chk("R3 zero no effect", v, 32'h9);
        wr(A_CLR, 32'h1);  rd(A_EN, v); chk("R4 clear", v, 32'h8);
        wr(A_CLR, 32'h0);  rd(A_EN, v); chk("R4 zero no effect", v, 32'h8);

        // R13 unknown / misaligned / out-of-range offsets
        wr(16'h0040, 32'hFFFF_FFFF);
        wr(A_SET + 16'd1, 32'hFFFF_FFFF);
        wr(A_PIN + 16'(4*NS), 32'h8000_0003);
        rd(A_EN, v);  chk("R13 write ignored", v, 32'h8);
        rd(16'h0040, v); chk("R13 unknown read", v, 0);
        rd(A_PIN + 16'(4*NS), v); chk("R13 beyond sources", v, 0);
        chk("R13 outputs untouched", 32'(irq), 0);
        wr(A_CLR, 32'h8);

        // R6 pin map rejection
        wr(A_PIN + 16'd8, 32'h8000_0003); rd(A_PIN + 16'd8, v); chk("R6 stored", v, 32'h8000_0003);
        wr(A_PIN + 16'd8, 32'h0000_0006); rd(A_PIN + 16'd8, v); chk("R6 rejected", v, 32'h8000_0003);
        wr(A_PIN + 16'd8, 32'h0000_0005); rd(A_PIN + 16'd8, v); chk("R6 flag cleared", v, 32'h5);

        // R7 one-hot core map
        wr(A_CORE + 16'd32, 32'h6); rd(A_CORE + 16'd32, v); chk("R7 lowest bit", v, 32'h2);
        wr(A_CORE + 16'd32, 32'h4); rd(A_CORE + 16'd32, v); chk("R7 core out of range", v, 32'h2);
        rd(A_CORE, v); chk("R7 stride", v, 0);
        wr(A_CORE + 16'd32, 32'h0); rd(A_CORE + 16'd32, v); chk("R7 unmap", v, 0);

        // R10 software trigger
        wr(A_PIN + 16'd20, 32'h8000_0003);
        wr(A_CORE + 16'd160, 32'h1);
        wr(A_SET, 32'h20);
        wr(A_TRIG, 32'h8000_0005);
        chk("R10 set raises line", 32'(irq), 32'h20);
        rd(A_PEND, v); chk("R10 pending set", v, 32'h20);
        wr(A_TRIG, 32'h0000_0005);
        chk("R10 clear drops line", 32'(irq), 0);
        wr(A_TRIG, 32'h8000_0010);
        wr(A_TRIG, 32'hFFFF_FFFF);
        rd(A_PEND, v); chk("R10 out-of-range ignored", v, 0);
        wr(A_CLR, 32'h20);

        // R11 pending recorded while disabled
        wr(A_PIN + 16'd28, 32'h8000_0000);
        wr(A_CORE + 16'd224, 32'h2);
        src[7] = 1'b1; tick();
        chk("R11 still silent", 32'(irq), 0);
        wr(A_SET, 32'h80);
        chk("R11 enable after pending", 32'(irq), 32'h400);
        src[7] = 1'b0; tick();
        chk("R11 level drop recorded", 32'(irq), 0);
        wr(A_CLR, 32'h80);

        // R12 registered output timing
        wr(A_PIN + 16'd36, 32'h8000_0001);
        wr(A_CORE + 16'd288, 32'h1);
        wr(A_SET, 32'h200);
        src[9] = 1'b1;
        #1;
        chk("R12 before edge", 32'(irq), 0);
        @(negedge clk);
        chk("R12 after edge", 32'(irq), 32'h8);
        src[9] = 1'b0; tick();
        wr(A_CLR, 32'h200);

        // R9 local compare
        wr(A_LOC + 16'd12, 32'h8000_0004);
        cmp = 2'b11; tick();
        chk("R9 both cores", 32'(irq), 32'h4004);
        wr(A_LOC + 16'd8, 32'h0);
        chk("R9 mask off", 32'(irq), 32'h0004);
        wr(A_LOC + 16'd4, 32'h0000_0006);
        chk("R9 R6 cmp pin reject", 32'(irq), 32'h0004);
        rd(A_LOC + 16'd4, v); chk("R6 cmp pin kept", v, 32'h8000_0000);
        cmp = 2'b00; tick();
        chk("R9 released", 32'(irq), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule